// File: doc/BRIEF.md
# Bus Node Fault Confinement Controller

This block keeps track of how healthy a node on a shared serial bus is. An upstream bus engine that has already classified each fault sends it single-cycle pulses, one line for faults seen while the node was sending and one for faults seen while it was listening. The block counts the two kinds separately, in saturating 9-bit counters. From the larger of the two counts it derives a confinement level: fully active, passive (the node's rights on the bus are restricted), or cut off (the node must not drive the bus at all).

The transmit path reads two registered flags. One grants permission to transmit. The other marks restricted rights. The block has no decrement path and no timed recovery. The only way back to full operation is an explicit request to clear the counts, or the synchronous reset.

Top module: `fault_confine_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets both counts to 0, `conf_state` to 2'b00, `tx_permit` to 1 and `restricted` to 0, all visible after the clock edge that samples it.
- R2: A `tx_fault` pulse raises `tx_count` by one at the next edge and leaves `rx_count` unchanged.
- R3: An `rx_fault` pulse raises `rx_count` by one at the next edge and leaves `tx_count` unchanged.
- R4: When `tx_fault` and `rx_fault` are high in the same cycle, both counts rise by one at the next edge.
- R5: `conf_state` is 2'b01 (passive) whenever the larger count is at least 127 and below 256. It changes in the same cycle as the count that causes it.
- R6: `conf_state` is 2'b10 (cut off) whenever either count is 256 or more. This takes precedence over passive. Otherwise `conf_state` is 2'b00 (active).
- R7: `tx_permit` is a register. It is low in exactly the cycles that follow a cycle with `conf_state` at 2'b10, and high in all other cycles.
- R8: `restricted` is a register. It is high in exactly the cycles that follow a cycle with `conf_state` at 2'b01.
- R9: Each count saturates at 511. Further faults of that kind leave it at 511.
- R10: `clr_counts` sets both counts to 0 at the next edge, even when fault pulses arrive in the same cycle. `conf_state` then reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fault | input | 1 | One-cycle pulse: fault seen while sending |
| rx_fault | input | 1 | One-cycle pulse: fault seen while listening |
| clr_counts | input | 1 | Request to clear both counts |
| tx_count | output | 9 | Sending-fault count |
| rx_count | output | 9 | Listening-fault count |
| conf_state | output | 2 | 00 active, 01 passive, 10 cut off |
| tx_permit | output | 1 | Registered permission to transmit |
| restricted | output | 1 | Registered restricted-rights flag |

## Verification
Both counts are outputs, so a miscounted fault appears at the ports in the first cycle after the edge that should have changed the count. A wrong confinement level shows on `conf_state` in that same cycle. It reaches `tx_permit` and `restricted` one cycle later. An error in saturation or in clear priority therefore surfaces at most two cycles after the stimulus that provokes it. The bench compares every output against a behavioural model on every cycle. It drives long runs past 127, 256 and 511, and it drives coincident faults and coincident clears.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_CUTOFF  = 2'b10
  } fc_level_e;

  // Classify a level against two thresholds; the higher threshold wins.
  function automatic fc_level_e fc_classify(input int unsigned level,
                                            input int unsigned passive_at,
                                            input int unsigned cutoff_at);
    if (level >= cutoff_at)       return FC_CUTOFF;
    else if (level >= passive_at) return FC_PASSIVE;
    else                          return FC_ACTIVE;
  endfunction

endpackage

// File: rtl/fc_counter.sv
module fc_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             at_ceiling
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  assign at_ceiling = (count == CEIL);

  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (bump && !at_ceiling)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/fc_level_decode.sv
module fc_level_decode
  import fc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int PASSIVE_AT = 127,
  parameter int CUTOFF_AT  = 256
) (
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic [CNT_W-1:0] worst,
  output fc_level_e        level
);
  assign worst = (cnt_a >= cnt_b) ? cnt_a : cnt_b;

  always_comb begin
    level = fc_classify(int'(unsigned'(worst)), PASSIVE_AT, CUTOFF_AT);
  end
endmodule

// File: rtl/fc_flag_regs.sv
module fc_flag_regs
  import fc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fc_level_e level,
  output logic      tx_permit,
  output logic      restricted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_permit  <= 1'b1;
      restricted <= 1'b0;
    end else begin
      tx_permit  <= (level != FC_CUTOFF);
      restricted <= (level == FC_PASSIVE);
    end
  end
endmodule

// File: rtl/fault_confine_ctrl.sv
module fault_confine_ctrl
  import fc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int PASSIVE_AT = 127,
  parameter int CUTOFF_AT  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_fault,
  input  logic             rx_fault,
  input  logic             clr_counts,
  output logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] rx_count,
  output logic [1:0]       conf_state,
  output logic             tx_permit,
  output logic             restricted
);
  localparam int NUM_CNT = 2;

  logic [NUM_CNT-1:0]             bump_vec;
  logic [NUM_CNT-1:0]             ceil_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_vec;
  logic [CNT_W-1:0]               worst_cnt;
  fc_level_e                      level;

  // Named internal events for the checker.
  logic tx_at_ceiling;
  logic rx_at_ceiling;

  assign bump_vec = {rx_fault, tx_fault};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    fc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .bump       (bump_vec[i]),
      .clear      (clr_counts),
      .count      (cnt_vec[i]),
      .at_ceiling (ceil_vec[i])
    );
  end

  assign tx_count      = cnt_vec[0];
  assign rx_count      = cnt_vec[1];
  assign tx_at_ceiling = ceil_vec[0];
  assign rx_at_ceiling = ceil_vec[1];

  fc_level_decode #(
    .CNT_W      (CNT_W),
    .PASSIVE_AT (PASSIVE_AT),
    .CUTOFF_AT  (CUTOFF_AT)
  ) u_dec (
    .cnt_a (tx_count),
    .cnt_b (rx_count),
    .worst (worst_cnt),
    .level (level)
  );

  assign conf_state = level;

  fc_flag_regs u_flags (
    .clk        (clk),
    .rst        (rst),
    .level      (level),
    .tx_permit  (tx_permit),
    .restricted (restricted)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int CNT_W      = 9,
  parameter int PASSIVE_AT = 127,
  parameter int CUTOFF_AT  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_fault,
  input logic             rx_fault,
  input logic             clr_counts,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [1:0]       conf_state,
  input logic             tx_permit,
  input logic             restricted,
  input logic             tx_at_ceiling,
  input logic             rx_at_ceiling
);
  localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_AT);
  localparam logic [CNT_W-1:0] C_LIM = CNT_W'(CUTOFF_AT);
  localparam logic [CNT_W-1:0] CEIL  = {CNT_W{1'b1}};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (tx_count == '0 && rx_count == '0 && tx_permit && !restricted));

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_fault && !clr_counts && !tx_at_ceiling)
      |=> tx_count == $past(tx_count) + CNT_W'(1));

  assert_rx_step_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_fault && !clr_counts && !rx_at_ceiling)
      |=> rx_count == $past(rx_count) + CNT_W'(1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tx_fault && !rx_fault && !clr_counts) |=> ($stable(tx_count) && $stable(rx_count)));

  assert_passive_R5: assert property (@(posedge clk) disable iff (rst)
    ((tx_count >= P_LIM || rx_count >= P_LIM) && tx_count < C_LIM && rx_count < C_LIM)
      |-> conf_state == 2'b01);

  assert_cutoff_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_count >= C_LIM || rx_count >= C_LIM) |-> conf_state == 2'b10);

  assert_no_send_R7: assert property (@(posedge clk) disable iff (rst)
    (conf_state == 2'b10) |=> !tx_permit);

  assert_restrict_R8: assert property (@(posedge clk) disable iff (rst)
    (conf_state == 2'b01) |=> restricted);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(restricted && !tx_permit));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_count == CEIL && !clr_counts) |=> tx_count == CEIL);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr_counts |=> (tx_count == '0 && rx_count == '0 && conf_state == 2'b00));
endmodule

bind fault_confine_ctrl fc_checker #(
  .CNT_W      (CNT_W),
  .PASSIVE_AT (PASSIVE_AT),
  .CUTOFF_AT  (CUTOFF_AT)
) u_fc_checker (
  .clk           (clk),
  .rst           (rst),
  .tx_fault      (tx_fault),
  .rx_fault      (rx_fault),
  .clr_counts    (clr_counts),
  .tx_count      (tx_count),
  .rx_count      (rx_count),
  .conf_state    (conf_state),
  .tx_permit     (tx_permit),
  .restricted    (restricted),
  .tx_at_ceiling (tx_at_ceiling),
  .rx_at_ceiling (rx_at_ceiling)
);

// File: tb/fault_confine_ctrl_bench.sv
`timescale 1ns/1ps
module fault_confine_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_fault = 1'b0, rx_fault = 1'b0, clr_counts = 1'b0;
  logic [8:0] tx_count, rx_count;
  logic [1:0] conf_state;
  logic       tx_permit, restricted;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // Behavioural reference state.
  int m_tx = 0, m_rx = 0;
  int m_permit = 1, m_restr = 0;

  always #5 clk = ~clk;

  fault_confine_ctrl u_fault_confine_ctrl (
    .clk(clk), .rst(rst), .tx_fault(tx_fault), .rx_fault(rx_fault),
    .clr_counts(clr_counts), .tx_count(tx_count), .rx_count(rx_count),
    .conf_state(conf_state), .tx_permit(tx_permit), .restricted(restricted)
  );

  function automatic int expect_level(int a, int b);
    int hi;
    hi = (a > b) ? a : b;
    if (hi >= 256) return 2;
    if (hi >= 127) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Reference model: flags take the level seen before the edge, counts follow inputs.
  always @(posedge clk) begin
    int lvl;
    cycles++;
    lvl = expect_level(m_tx, m_rx);
    if (rst) begin
      m_tx = 0; m_rx = 0; m_permit = 1; m_restr = 0;
    end else begin
      m_permit = (lvl != 2) ? 1 : 0;
      m_restr  = (lvl == 1) ? 1 : 0;
      if (clr_counts) begin
        m_tx = 0; m_rx = 0;
      end else begin
        if (tx_fault && m_tx < 511) m_tx++;
        if (rx_fault && m_rx < 511) m_rx++;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!finished && cycles > 0) begin
      check("R2 tx_count", int'(tx_count), m_tx);
      check("R3 rx_count", int'(rx_count), m_rx);
      check("R5 R6 conf_state", int'(conf_state), expect_level(m_tx, m_rx));
      check("R7 tx_permit", int'(tx_permit), m_permit);
      check("R8 restricted", int'(restricted), m_restr);
    end
  end

  task automatic step(bit t, bit r, bit c);
    @(negedge clk);
    #1;
    tx_fault = t; rx_fault = r; clr_counts = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // Watchdog
  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d cycles", cycles, 200000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    step(0, 0, 0);
    rst = 1'b0;
    // R1: state right after reset
    check("R1 tx_count", int'(tx_count), 0);
    check("R1 rx_count", int'(rx_count), 0);
    check("R1 conf_state", int'(conf_state), 0);
    check("R1 tx_permit", int'(tx_permit), 1);
    check("R1 restricted", int'(restricted), 0);

    // R4: simultaneous faults
    step(1, 1, 0);
    step(0, 0, 0);
    check("R4 tx_count", int'(tx_count), 1);
    check("R4 rx_count", int'(rx_count), 1);

    // R2 / R5: walk tx into passive
    for (int i = 0; i < 126; i++) step(1, 0, 0);
    step(0, 0, 0);
    check("R5 conf_state at 127", int'(conf_state), 1);
    check("R3 rx untouched", int'(rx_count), 1);
    idle(2);
    check("R8 restricted", int'(restricted), 1);

    // R6 / R7: continue tx into cut-off
    for (int i = 0; i < 129; i++) step(1, 0, 0);
    step(0, 0, 0);
    check("R6 tx_count", int'(tx_count), 256);
    check("R6 conf_state", int'(conf_state), 2);
    idle(1);
    check("R7 tx_permit", int'(tx_permit), 0);

    // R10: clear overrides coincident pulses
    step(1, 1, 1);
    step(0, 0, 0);
    check("R10 tx_count", int'(tx_count), 0);
    check("R10 rx_count", int'(rx_count), 0);
    check("R10 conf_state", int'(conf_state), 0);
    idle(2);

    // R3 / R9: rx up past saturation
    for (int i = 0; i < 530; i++) step(0, 1, 0);
    step(0, 0, 0);
    check("R9 rx saturated", int'(rx_count), 511);
    check("R3 tx untouched", int'(tx_count), 0);
    for (int i = 0; i < 520; i++) step(1, 0, 0);
    step(0, 0, 0);
    check("R9 tx saturated", int'(tx_count), 511);

    // R1: reset in the middle of operation
    rst = 1'b1;
    step(0, 0, 0);
    rst = 1'b0;
    check("R1 mid reset tx", int'(tx_count), 0);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int p;
      p = $urandom_range(0, 999);
      step(p < 250, (p % 3) == 0, p == 7);
    end
    idle(3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule